// File: doc/BRIEF.md
# Autoranging Rectifier Sequencing Controller

This controller runs the AC front end of an off-line supply from periodic bus-voltage readings. Each reading is an unsigned integer in volts with a one-cycle valid strobe. From these readings it decides when the hold-up capacitors have stopped charging, and at that point whether to engage the voltage-doubler strap. After that it decides whether to short out the inrush thermistor. Once the thermistor is bypassed, it releases the downstream converters and then reports a healthy bus, each after its own delay measured in milliseconds.

While running, the controller raises its power-fail warning when the bus sags. It shuts the converters off only at a lower threshold, so a brief dip rides through without a new start-up. Over-voltage and under-voltage trip it back to its initial state. After a trip it waits for the bus to drain before it tries again. All thresholds, the flatness window and both delays are parameters, so a bench can use short timings.

Top module: `rect_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `strap_o`, `bypass_o` and `enable_o` are 0 and `bus_ok_no` is 1. The bus-OK output is active low.
- R2: The charging slope is taken as flat on the sample that completes FLAT_N consecutive sample-to-sample differences of at most FLAT_DELTA volts (defaults 4 and 1). If the first such decision sees a bus below DBL_TH (200), `strap_o` goes to 1. At exactly DBL_TH or above, it stays 0.
- R3: `bypass_o` goes to 1 only on a flat decision with the bus strictly above BYP_TH (235). A bus of exactly BYP_TH leaves it 0, and later flat samples are evaluated again.
- R4: Any difference larger than FLAT_DELTA resets the run of close samples. FLAT_N-1 close differences are not enough. Each decision that changes state starts a fresh run.
- R5: `enable_o` rises DELAY_MS*TICK_DIV+1 clock cycles after `bypass_o` rises. TICK_DIV is clocks per millisecond tick.
- R6: `bus_ok_no` falls DELAY_MS*TICK_DIV+1 cycles after `enable_o` rises.
- R7: While running, a sample below OK_TH (205) drives `bus_ok_no` to 1 and keeps `enable_o` at 1. A later sample at or above OK_TH returns `bus_ok_no` to 0 without a restart.
- R8: While running, a sample below DIS_TH (190) clears `enable_o`, `bypass_o` and `strap_o` and sets `bus_ok_no`. A sample of exactly DIS_TH does not. After such a drop, the full power-up sequence repeats.
- R9: A sample above OV_TH (400) clears `enable_o` and `bypass_o` on the next cycle. Exactly OV_TH has no effect.
- R10: A sample below UV_TH (180) while the bypass is closed opens the bypass.
- R11: After an over- or under-voltage trip, samples at or above DIS_TH do not restart the sequence. The first sample below DIS_TH re-arms it, and charging then proceeds as at power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | One-cycle strobe marking a new bus reading |
| bus_v_i | input | VW | Bus voltage in volts, unsigned |
| strap_o | output | 1 | Voltage-doubler strap switch closed |
| bypass_o | output | 1 | Inrush thermistor bypass switch closed |
| enable_o | output | 1 | Downstream converter enable |
| bus_ok_no | output | 1 | Bus healthy, active low |

## Verification
The bench targets the threshold edges: 199 against 200 for the doubler, 235 against 236 for the bypass, 190 and 205 in the running state, and 400 against 401 for over-voltage. A design that compared with the wrong sense would double a high-line bus, or leave a marginal bus stuck behind the thermistor. It then checks the flatness count with a run one short and a run broken by a difference of two volts. Counting off by one would make the switches act too early. It measures the two delays to the exact cycle, so a timer that failed to restart between stages would show up at once. Finally, it drives a dip into the warning band and back, and feeds high samples after a trip. A design without hysteresis would restart on the dip, and one without the drain requirement would resume charging straight after a fault.

// File: rtl/rect_seq_pkg.sv
package rect_seq_pkg;
  typedef enum logic [2:0] {
    ST_CHARGE,
    ST_SETTLE,
    ST_WAIT_EN,
    ST_WAIT_OK,
    ST_RUN,
    ST_FAULT
  } seq_state_e;
endpackage

// File: rtl/rect_slope_det.sv
module rect_slope_det #(
  parameter int VW         = 10,
  parameter int FLAT_N     = 4,
  parameter int FLAT_DELTA = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [VW-1:0] bus_v_i,
  input  logic          restart_i,
  output logic          flat_hit_o
);
  localparam int CW = $clog2(FLAT_N + 1);

  logic [VW-1:0] prev_q, diff;
  logic          have_q, close;
  logic [CW-1:0] cnt_q;

  assign diff       = (bus_v_i >= prev_q) ? bus_v_i - prev_q : prev_q - bus_v_i;
  assign close      = have_q && (diff <= VW'(FLAT_DELTA));
  assign flat_hit_o = valid_i && close && (cnt_q >= CW'(FLAT_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (restart_i) begin
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (valid_i) begin
      prev_q <= bus_v_i;
      have_q <= 1'b1;
      if (!close)                     cnt_q <= '0;
      else if (cnt_q < CW'(FLAT_N))   cnt_q <= cnt_q + 1'b1;
    end
  end

  // a large step always breaks the run
  p_step_clears_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !restart_i && have_q && diff > VW'(FLAT_DELTA)) |=> (cnt_q == '0));

  p_restart_forgets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !flat_hit_o);
endmodule

// File: rtl/rect_ms_timer.sv
module rect_ms_timer #(
  parameter int TICK_DIV = 1000,
  parameter int DELAY_MS = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int MW = $clog2(DELAY_MS + 1);

  logic          tick;
  logic [MW-1:0] ms_q;

  generate
    if (TICK_DIV > 1) begin : g_presc
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q;
      assign tick = run_i && (pre_q == PW'(TICK_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pre_q <= '0;
        else if (clr_i)  pre_q <= '0;
        else if (run_i)  pre_q <= tick ? '0 : pre_q + 1'b1;
      end
      p_tick_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && run_i && pre_q == PW'(TICK_DIV - 1)) |=> (pre_q == '0));
    end else begin : g_direct
      assign tick = run_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ms_q <= '0;
    else if (clr_i)                             ms_q <= '0;
    else if (tick && ms_q < MW'(DELAY_MS))      ms_q <= ms_q + 1'b1;
  end

  assign done_o = (ms_q == MW'(DELAY_MS));

  p_ms_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick) |=> $stable(ms_q));
endmodule

// File: rtl/rect_seq_fsm.sv
module rect_seq_fsm
  import rect_seq_pkg::*;
#(
  parameter int VW     = 10,
  parameter int DBL_TH = 200,
  parameter int BYP_TH = 235,
  parameter int OK_TH  = 205,
  parameter int DIS_TH = 190,
  parameter int OV_TH  = 400,
  parameter int UV_TH  = 180
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [VW-1:0] bus_v_i,
  input  logic          flat_hit_i,
  input  logic          tmr_done_i,
  output logic          trans_o,
  output logic          timing_o,
  output logic          strap_o,
  output logic          bypass_o,
  output logic          enable_o,
  output logic          bus_ok_no
);
  seq_state_e st_q, st_d;
  logic strap_q, ok_q, strap_set;
  logic ov, uv, low;

  assign ov  = valid_i && (bus_v_i > VW'(OV_TH));
  assign uv  = valid_i && (bus_v_i < VW'(UV_TH));
  assign low = valid_i && (bus_v_i < VW'(DIS_TH));

  always_comb begin
    st_d      = st_q;
    strap_set = 1'b0;
    unique case (st_q)
      ST_CHARGE: begin
        if (ov) st_d = ST_FAULT;
        else if (flat_hit_i) begin
          if (bus_v_i < VW'(DBL_TH)) begin
            strap_set = 1'b1;
            st_d      = ST_SETTLE;
          end else if (bus_v_i > VW'(BYP_TH)) st_d = ST_WAIT_EN;
          else                                st_d = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (ov)                                          st_d = ST_FAULT;
        else if (flat_hit_i && bus_v_i > VW'(BYP_TH))    st_d = ST_WAIT_EN;
      end
      ST_WAIT_EN: begin
        if (ov || uv)        st_d = ST_FAULT;
        else if (tmr_done_i) st_d = ST_WAIT_OK;
      end
      ST_WAIT_OK: begin
        if (ov || uv)        st_d = ST_FAULT;
        else if (tmr_done_i) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (ov || uv)  st_d = ST_FAULT;
        else if (low)  st_d = ST_CHARGE;
      end
      ST_FAULT: begin
        if (low) st_d = ST_CHARGE;
      end
      default: st_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_CHARGE;
      strap_q <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q && (st_d == ST_CHARGE || st_d == ST_FAULT)) strap_q <= 1'b0;
      else if (strap_set)                                          strap_q <= 1'b1;
      if (st_q != ST_RUN && st_d == ST_RUN)  ok_q <= 1'b1;
      else if (st_q == ST_RUN && valid_i)    ok_q <= (bus_v_i >= VW'(OK_TH));
    end
  end

  assign trans_o   = (st_d != st_q);
  assign timing_o  = (st_q == ST_WAIT_EN) || (st_q == ST_WAIT_OK);
  assign strap_o   = strap_q;
  assign bypass_o  = (st_q == ST_WAIT_EN) || (st_q == ST_WAIT_OK) || (st_q == ST_RUN);
  assign enable_o  = (st_q == ST_WAIT_OK) || (st_q == ST_RUN);
  assign bus_ok_no = !((st_q == ST_RUN) && ok_q);

  p_strap_on_flat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strap_o) |-> $past(flat_hit_i && bus_v_i < VW'(DBL_TH)));
  p_bypass_on_flat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bypass_o) |-> $past(flat_hit_i && bus_v_i > VW'(BYP_TH)));
  p_enable_after_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enable_o) |-> $past(tmr_done_i));
  p_ok_needs_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ok_no) |-> $past(enable_o));
  p_warn_on_sag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && valid_i && bus_v_i < VW'(OK_TH)) |=> bus_ok_no);
  p_drop_below_dis_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && low) |=> !enable_o);
  p_ov_trip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov |=> (!enable_o && !bypass_o));
  p_uv_open_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_o && uv) |=> !bypass_o);
endmodule

// File: rtl/rect_seq_ctrl.sv
module rect_seq_ctrl #(
  parameter int VW         = 10,
  parameter int FLAT_N     = 4,
  parameter int FLAT_DELTA = 1,
  parameter int TICK_DIV   = 1000,
  parameter int DELAY_MS   = 150,
  parameter int DBL_TH     = 200,
  parameter int BYP_TH     = 235,
  parameter int OK_TH      = 205,
  parameter int DIS_TH     = 190,
  parameter int OV_TH      = 400,
  parameter int UV_TH      = 180
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_valid_i,
  input  logic [VW-1:0] bus_v_i,
  output logic          strap_o,
  output logic          bypass_o,
  output logic          enable_o,
  output logic          bus_ok_no
);
  logic flat_hit, trans, timing, tmr_done;

  rect_slope_det #(.VW(VW), .FLAT_N(FLAT_N), .FLAT_DELTA(FLAT_DELTA)) u_slope (
    .clk_i, .rst_ni,
    .valid_i    (sample_valid_i),
    .bus_v_i,
    .restart_i  (trans),
    .flat_hit_o (flat_hit)
  );

  rect_ms_timer #(.TICK_DIV(TICK_DIV), .DELAY_MS(DELAY_MS)) u_timer (
    .clk_i, .rst_ni,
    .clr_i  (trans),
    .run_i  (timing),
    .done_o (tmr_done)
  );

  rect_seq_fsm #(
    .VW(VW), .DBL_TH(DBL_TH), .BYP_TH(BYP_TH), .OK_TH(OK_TH),
    .DIS_TH(DIS_TH), .OV_TH(OV_TH), .UV_TH(UV_TH)
  ) u_fsm (
    .clk_i, .rst_ni,
    .valid_i    (sample_valid_i),
    .bus_v_i,
    .flat_hit_i (flat_hit),
    .tmr_done_i (tmr_done),
    .trans_o    (trans),
    .timing_o   (timing),
    .strap_o, .bypass_o, .enable_o, .bus_ok_no
  );
endmodule

// File: tb/rect_seq_ctrl_tb_top.sv
module rect_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VW         = 10;
  localparam int TICK_DIV   = 3;
  localparam int DELAY_MS   = 4;
  localparam int DLY        = DELAY_MS * TICK_DIV + 1;
  localparam int NTBL       = 18;
  // {volts, expected strap, expected bypass}
  localparam logic [11:0] TBL [NTBL] = '{
    {10'd50, 2'b00}, {10'd100, 2'b00}, {10'd150, 2'b00}, {10'd170, 2'b00},
    {10'd171, 2'b00}, {10'd170, 2'b00}, {10'd172, 2'b00}, {10'd172, 2'b00},
    {10'd172, 2'b00}, {10'd172, 2'b00}, {10'd172, 2'b10}, {10'd250, 2'b10},
    {10'd300, 2'b10}, {10'd340, 2'b10}, {10'd340, 2'b10}, {10'd340, 2'b10},
    {10'd341, 2'b10}, {10'd340, 2'b11}
  };

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic [VW-1:0] bus = '0;
  logic strap, byp, en, ok_n;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rect_seq_ctrl #(.VW(VW), .TICK_DIV(TICK_DIV), .DELAY_MS(DELAY_MS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(vld), .bus_v_i(bus),
    .strap_o(strap), .bypass_o(byp), .enable_o(en), .bus_ok_no(ok_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int v);
    bus = VW'(v);
    vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic send_n(input int v, input int n);
    for (int i = 0; i < n; i++) send(v);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    // R1 during reset
    chk("R1 strap", strap, 0); chk("R1 bypass", byp, 0);
    chk("R1 enable", en, 0);   chk("R1 bus_ok_n", ok_n, 1);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 bus_ok_n after release", ok_n, 1);

    // R2/R3/R4: charging table
    for (int i = 0; i < NTBL; i++) begin
      send(int'(TBL[i][11:2]));
      chk($sformatf("R2 R4 strap step %0d", i), strap, int'(TBL[i][1]));
      chk($sformatf("R3 R4 bypass step %0d", i), byp, int'(TBL[i][0]));
    end

    // R5 enable delay
    wait_cyc(DLY - 1);
    chk("R5 enable early", en, 0);
    wait_cyc(1);
    chk("R5 enable on time", en, 1);
    chk("R6 bus_ok_n with enable", ok_n, 1);
    // R6 bus-ok delay
    wait_cyc(DLY - 1);
    chk("R6 bus_ok_n early", ok_n, 1);
    wait_cyc(1);
    chk("R6 bus_ok_n on time", ok_n, 0);

    // R7 ride-through
    send(204); chk("R7 warn at 204", ok_n, 1); chk("R7 enable held", en, 1);
    send(205); chk("R7 ok back at 205", ok_n, 0);
    send(190); chk("R8 enable held at 190", en, 1); chk("R7 warn at 190", ok_n, 1);
    send(340); chk("R7 no restart ok", ok_n, 0); chk("R7 no restart strap", strap, 1);
    // R8 disable
    send(189);
    chk("R8 enable off", en, 0); chk("R8 bypass off", byp, 0);
    chk("R8 strap off", strap, 0); chk("R8 bus_ok_n", ok_n, 1);

    // R8 repeat sequence, R2 boundary, R3 boundary
    send_n(200, 5);
    chk("R2 no strap at 200", strap, 0); chk("R3 no bypass at 200", byp, 0);
    send_n(235, 5);
    chk("R3 no bypass at 235", byp, 0);
    send(236);
    chk("R3 bypass at 236", byp, 1);
    // R10 under-voltage in wait
    send(179);
    chk("R10 bypass opened", byp, 0); chk("R10 enable", en, 0);
    // R11 no restart without drain
    send_n(300, 6);
    chk("R11 held off", byp, 0);
    send(150);
    send_n(300, 4);
    chk("R11 flat not yet", byp, 0);
    send(300);
    chk("R11 restart bypass", byp, 1);
    wait_cyc(2 * DLY + 2);
    chk("R5 running enable", en, 1); chk("R6 running ok", ok_n, 0);
    // R9 over-voltage
    send(400); chk("R9 no trip at 400", en, 1);
    send(401);
    chk("R9 enable off", en, 0); chk("R9 bypass off", byp, 0);
    chk("R9 bus_ok_n", ok_n, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule